// File: doc/BRIEF.md
# Cache Line Retirement Controller

This controller sits beside the read path of a cache protected by single-error-correct, double-error-detect ECC. It watches the error events the decoder reports. When a line reports a corrected error, the controller reads the same line a second time. If the second read also needs correction, the fault is taken to be a lasting defect in that line. The controller then asks for the line's data to be copied to a spare location and sets that line's bit in a disable bitmap. If the second read comes back clean, the first error is treated as a transient upset, and the line stays in service.

Only one confirmation sequence runs at a time. Corrected events that arrive while a sequence is running are counted as dropped and are otherwise ignored. An uncorrectable error never enters the retirement flow. It is reported on a fatal pulse together with the line index. A retirement count saturates at a configured ceiling, and once that ceiling is reached no further lines are retired.

The error event input has no back-pressure: each valid cycle is one event, and it is either used or discarded in that same cycle. The re-read request is a valid/ready channel. The request holds its index stable until ready is seen, and a transfer happens in any cycle where valid and ready are both high. The re-read response is valid-only and is expected only after the request has been accepted. The relocation request stays high with a stable index until the acknowledge arrives.

Top module: `line_retire_ctrl`

## Requirements
- R1: After reset the disable bitmap, retire count and drop count are zero, and no re-read request, relocation request or fatal pulse is active.
- R2: A corrected event (corrected=1, uncorrectable=0) on an in-range line that is not disabled, arriving while idle and below the ceiling, raises the re-read request for that same index in the next cycle.
- R3: A pending re-read request holds valid high and its index stable until the cycle in which ready is high. That cycle is the transfer, and valid is low in the following cycle.
- R4: A re-read response with corrected=0 and uncorrectable=0 returns the controller to idle. It issues no relocation request and leaves the bitmap unchanged.
- R5: A re-read response with corrected=1 and uncorrectable=0 raises the relocation request in the next cycle, carrying the line index. The request is held with a stable index until the acknowledge is seen.
- R6: At the acknowledged edge, bit N of the bitmap (where N is the line index) is set and the retire count increases by one. The controller is idle in the next cycle.
- R7: Disable bits are cleared only by reset. Once set, a bit stays set, and the number of set bits always equals the retire count.
- R8: A corrected event arriving while a sequence is in progress, including the cycle in which the relocation acknowledge arrives, increases the drop count by one (saturating) and starts nothing.
- R9: An event flagged uncorrectable (regardless of its corrected flag), or a re-read response flagged uncorrectable, produces a one-cycle fatal pulse in the next cycle with that line's index. Such an event starts no sequence, and such a response ends the sequence with no relocation.
- R10: Once the retire count equals MAX_RETIRE, corrected events start no sequence and are not counted as drops.
- R11: A corrected event on a line that is already disabled starts no sequence and is not counted as a drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An ECC event is present this cycle |
| evt_idx | input | IDX_W | Line index of the event |
| evt_corr | input | 1 | Event carried a corrected single-bit error |
| evt_uncorr | input | 1 | Event carried an uncorrectable error |
| rd_req_valid | output | 1 | Re-read request valid |
| rd_req_ready | input | 1 | Re-read request accepted |
| rd_req_idx | output | IDX_W | Line to re-read |
| rd_rsp_valid | input | 1 | Re-read result present |
| rd_rsp_corr | input | 1 | Re-read needed correction |
| rd_rsp_uncorr | input | 1 | Re-read was uncorrectable |
| mv_req_valid | output | 1 | Relocation request for a defective line |
| mv_req_idx | output | IDX_W | Line whose data is to be relocated |
| mv_ack | input | 1 | Relocation finished |
| disable_map | output | NUM_LINES | One bit per line, set when the line is retired |
| retire_count | output | CNT_W | Number of retired lines |
| drop_count | output | DROP_W | Corrected events discarded while busy (saturating) |
| fatal | output | 1 | One-cycle uncorrectable error pulse |
| fatal_idx | output | IDX_W | Line index for the fatal pulse |

## Verification
Two functions can fall in the same cycle: the last step of a retirement, when the relocation acknowledge sets the disable bit, and the arrival of a new corrected event for a different line. The bench provokes this by driving the acknowledge and the event in the same cycle. It then expects three things: the retired line's bit and the retire count are updated, the drop count rises by one, and no re-read request appears for the new line in the next cycle. Separately, back-pressure on the re-read channel is held for several cycles while a second event arrives, to confirm that the request stays stable and the newcomer is dropped.

// File: rtl/retire_pkg.sv
package retire_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2,
    SEQ_MOVE  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (inc && count != TOP)  count <= count + 1'b1;
  end

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP) |=> (count == TOP));
endmodule

// File: rtl/retire_seq.sv
module retire_seq
  import retire_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  output logic             busy,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [IDX_W-1:0] rd_req_idx,
  input  logic             rd_rsp_valid,
  input  logic             rd_rsp_corr,
  input  logic             rd_rsp_uncorr,
  output logic             mv_req_valid,
  output logic [IDX_W-1:0] mv_req_idx,
  input  logic             mv_ack,
  output logic             retire_pulse,
  output logic             rsp_fatal
);
  seq_state_t       state;
  logic [IDX_W-1:0] line_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      line_q <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE:  if (start) begin
                     state  <= SEQ_ISSUE;
                     line_q <= start_idx;
                   end
        SEQ_ISSUE: if (rd_req_ready) state <= SEQ_WAIT;
        SEQ_WAIT:  if (rd_rsp_valid)
                     state <= (rd_rsp_corr && !rd_rsp_uncorr) ? SEQ_MOVE : SEQ_IDLE;
        SEQ_MOVE:  if (mv_ack) state <= SEQ_IDLE;
        default:   state <= SEQ_IDLE;
      endcase
    end
  end

  assign busy         = (state != SEQ_IDLE);
  assign rd_req_valid = (state == SEQ_ISSUE);
  assign rd_req_idx   = line_q;
  assign mv_req_valid = (state == SEQ_MOVE);
  assign mv_req_idx   = line_q;
  assign retire_pulse = (state == SEQ_MOVE) && mv_ack;
  assign rsp_fatal    = (state == SEQ_WAIT) && rd_rsp_valid && rd_rsp_uncorr;

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_idx)));
  // R3
  rd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> !rd_req_valid);
  // R5
  mv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_req_valid && !mv_ack) |=> (mv_req_valid && $stable(mv_req_idx)));
  // R2
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_valid, mv_req_valid}));
endmodule

// File: rtl/line_mask.sv
module line_mask #(
  parameter int NUM_LINES  = 16,
  parameter int MAX_RETIRE = 4,
  parameter int IDX_W      = 4,
  parameter int CNT_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set,
  input  logic [IDX_W-1:0]     set_idx,
  output logic [NUM_LINES-1:0] disable_map,
  output logic [CNT_W-1:0]     retire_count,
  output logic                 at_cap
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_RETIRE);

  assign at_cap = (retire_count == CAP);

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_bit
      always_ff @(posedge clk) begin
        if (!rst_n)                                          disable_map[g] <= 1'b0;
        else if (set && !at_cap && set_idx == IDX_W'(g))     disable_map[g] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)              retire_count <= '0;
    else if (set && !at_cap) retire_count <= retire_count + 1'b1;
  end

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((disable_map & $past(disable_map)) == $past(disable_map)));
  // R7
  pop_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(disable_map) == int'(retire_count));
  // R10
  cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(retire_count) <= MAX_RETIRE);
endmodule

// File: rtl/line_retire_ctrl.sv
module line_retire_ctrl #(
  parameter int NUM_LINES  = 16,
  parameter int MAX_RETIRE = 4,
  parameter int DROP_W     = 8,
  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int CNT_W     = $clog2(MAX_RETIRE + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  input  logic [IDX_W-1:0]     evt_idx,
  input  logic                 evt_corr,
  input  logic                 evt_uncorr,
  output logic                 rd_req_valid,
  input  logic                 rd_req_ready,
  output logic [IDX_W-1:0]     rd_req_idx,
  input  logic                 rd_rsp_valid,
  input  logic                 rd_rsp_corr,
  input  logic                 rd_rsp_uncorr,
  output logic                 mv_req_valid,
  output logic [IDX_W-1:0]     mv_req_idx,
  input  logic                 mv_ack,
  output logic [NUM_LINES-1:0] disable_map,
  output logic [CNT_W-1:0]     retire_count,
  output logic [DROP_W-1:0]    drop_count,
  output logic                 fatal,
  output logic [IDX_W-1:0]     fatal_idx
);
  localparam logic [IDX_W:0] LINE_LIMIT = (IDX_W+1)'(NUM_LINES);

  logic busy, at_cap, retire_pulse, rsp_fatal;
  logic evt_is_fatal, evt_is_corr, in_range, line_off, start, drop_inc;

  assign evt_is_fatal = evt_valid && evt_uncorr;
  assign evt_is_corr  = evt_valid && evt_corr && !evt_uncorr;
  assign in_range     = ({1'b0, evt_idx} < LINE_LIMIT);
  assign line_off     = in_range ? disable_map[evt_idx] : 1'b1;
  assign start        = evt_is_corr && !busy && !at_cap && !line_off;
  assign drop_inc     = evt_is_corr && busy && !at_cap && !line_off;

  retire_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_idx(evt_idx), .busy(busy),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_idx(rd_req_idx),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_corr(rd_rsp_corr), .rd_rsp_uncorr(rd_rsp_uncorr),
    .mv_req_valid(mv_req_valid), .mv_req_idx(mv_req_idx), .mv_ack(mv_ack),
    .retire_pulse(retire_pulse), .rsp_fatal(rsp_fatal)
  );

  line_mask #(.NUM_LINES(NUM_LINES), .MAX_RETIRE(MAX_RETIRE), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .set(retire_pulse), .set_idx(mv_req_idx),
    .disable_map(disable_map), .retire_count(retire_count), .at_cap(at_cap)
  );

  sat_counter #(.W(DROP_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .inc(drop_inc), .count(drop_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fatal     <= 1'b0;
      fatal_idx <= '0;
    end else begin
      fatal <= evt_is_fatal || rsp_fatal;
      if (evt_is_fatal)   fatal_idx <= evt_idx;
      else if (rsp_fatal) fatal_idx <= rd_req_idx;
    end
  end

  // R9
  fatal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal && !$past(evt_valid && evt_uncorr) && !$past(rd_rsp_valid && rd_rsp_uncorr)) |-> 1'b0);
  // R2
  start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && evt_valid && evt_corr && !evt_uncorr && in_range && !disable_map[evt_idx] && !at_cap)
      |=> (rd_req_valid && rd_req_idx == $past(evt_idx)));
  // R11
  off_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && evt_valid && line_off) |=> !rd_req_valid);
endmodule

// File: tb/sim_line_retire_ctrl.sv
module sim_line_retire_ctrl;
  localparam int CLK_P = 10;
  localparam int NL = 16;
  localparam int MR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 0, evt_corr = 0, evt_uncorr = 0;
  logic [3:0] evt_idx = '0;
  logic rd_req_valid, rd_req_ready = 0;
  logic [3:0] rd_req_idx, mv_req_idx, fatal_idx;
  logic rd_rsp_valid = 0, rd_rsp_corr = 0, rd_rsp_uncorr = 0;
  logic mv_req_valid, mv_ack = 0, fatal;
  logic [NL-1:0] disable_map;
  logic [2:0] retire_count;
  logic [7:0] drop_count;

  int checks = 0, fails = 0;
  logic [NL-1:0] exp_map = '0;
  int exp_cnt = 0, exp_drop = 0;

  // table entry: {line[3:0], reread_corrected}
  localparam logic [4:0] VEC [5] = '{ {4'd3,1'b1}, {4'd5,1'b0}, {4'd9,1'b1}, {4'd0,1'b1}, {4'd15,1'b0} };

  always #(CLK_P/2) clk = ~clk;

  line_retire_ctrl #(.NUM_LINES(NL), .MAX_RETIRE(MR), .DROP_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_idx(evt_idx), .evt_corr(evt_corr),
    .evt_uncorr(evt_uncorr), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_idx(rd_req_idx), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_corr(rd_rsp_corr),
    .rd_rsp_uncorr(rd_rsp_uncorr), .mv_req_valid(mv_req_valid), .mv_req_idx(mv_req_idx),
    .mv_ack(mv_ack), .disable_map(disable_map), .retire_count(retire_count),
    .drop_count(drop_count), .fatal(fatal), .fatal_idx(fatal_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send_evt(input logic [3:0] idx, input logic c, input logic u);
    evt_valid = 1; evt_idx = idx; evt_corr = c; evt_uncorr = u;
    tick();
    evt_valid = 0; evt_corr = 0; evt_uncorr = 0;
  endtask

  task automatic accept_req();
    rd_req_ready = 1; tick(); rd_req_ready = 0;
  endtask

  task automatic respond(input logic c, input logic u);
    rd_rsp_valid = 1; rd_rsp_corr = c; rd_rsp_uncorr = u;
    tick();
    rd_rsp_valid = 0; rd_rsp_corr = 0; rd_rsp_uncorr = 0;
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    tick(); tick();
    // R1 reset state
    chk("R1 map", disable_map, 0);
    chk("R1 count", retire_count, 0);
    chk("R1 drops", drop_count, 0);
    chk("R1 outs", {rd_req_valid, mv_req_valid, fatal}, 0);
    rst_n = 1; tick();

    // table-driven sequences: R2 R3 R4 R5 R6
    for (int i = 0; i < 5; i++) begin
      logic [3:0] ln;
      logic rc;
      ln = VEC[i][4:1]; rc = VEC[i][0];
      send_evt(ln, 1'b1, 1'b0);
      chk("R2 req", {rd_req_valid, rd_req_idx}, {1'b1, ln});
      accept_req();
      chk("R3 req dropped after transfer", rd_req_valid, 0);
      respond(rc, 1'b0);
      if (rc) begin
        chk("R5 move", {mv_req_valid, mv_req_idx}, {1'b1, ln});
        mv_ack = 1; tick(); mv_ack = 0;
        exp_map[ln] = 1'b1; exp_cnt++;
        chk("R6 move cleared", mv_req_valid, 0);
      end else begin
        chk("R4 no move", mv_req_valid, 0);
      end
      chk("R6/R4 map", disable_map, exp_map);
      chk("R6 count", retire_count, exp_cnt);
    end

    // R9 uncorrectable re-read response
    send_evt(4'd11, 1'b1, 1'b0);
    accept_req();
    respond(1'b0, 1'b1);
    chk("R9 rsp fatal", {fatal, fatal_idx}, {1'b1, 4'd11});
    chk("R9 no move", mv_req_valid, 0);
    tick();
    chk("R9 pulse one cycle", fatal, 0);
    chk("R9 map", disable_map, exp_map);

    // R11 event on a disabled line
    send_evt(4'd3, 1'b1, 1'b0);
    chk("R11 no req", rd_req_valid, 0);
    chk("R11 no drop", drop_count, exp_drop);

    // R3 back-pressure with R8 drop while busy
    send_evt(4'd7, 1'b1, 1'b0);
    tick();
    chk("R3 held", {rd_req_valid, rd_req_idx}, {1'b1, 4'd7});
    send_evt(4'd2, 1'b1, 1'b0);
    exp_drop++;
    chk("R3 held under new event", {rd_req_valid, rd_req_idx}, {1'b1, 4'd7});
    chk("R8 drop while waiting", drop_count, exp_drop);
    accept_req();
    respond(1'b1, 1'b0);
    tick();
    chk("R5 move held", {mv_req_valid, mv_req_idx}, {1'b1, 4'd7});
    // R8 same-cycle ack and new event
    mv_ack = 1; evt_valid = 1; evt_idx = 4'd4; evt_corr = 1;
    tick();
    mv_ack = 0; evt_valid = 0; evt_corr = 0;
    exp_map[7] = 1'b1; exp_cnt++; exp_drop++;
    chk("R8 same-cycle map", disable_map, exp_map);
    chk("R8 same-cycle count", retire_count, exp_cnt);
    chk("R8 same-cycle drop", drop_count, exp_drop);
    chk("R8 no start", rd_req_valid, 0);

    // R10 ceiling reached
    send_evt(4'd4, 1'b1, 1'b0);
    chk("R10 no req", rd_req_valid, 0);
    chk("R10 no drop", drop_count, exp_drop);
    tick();
    chk("R10 map", disable_map, exp_map);

    // R9 uncorrectable events
    send_evt(4'd6, 1'b0, 1'b1);
    chk("R9 evt fatal", {fatal, fatal_idx}, {1'b1, 4'd6});
    chk("R9 no req", rd_req_valid, 0);
    tick();
    chk("R9 low after", fatal, 0);
    send_evt(4'd10, 1'b1, 1'b1);
    chk("R9 both flags", {fatal, fatal_idx, rd_req_valid}, {1'b1, 4'd10, 1'b0});

    // R7 only reset clears
    rst_n = 0; tick();
    chk("R7 reset clears map", disable_map, 0);
    chk("R1 count after reset", retire_count, 0);
    chk("R1 drops after reset", drop_count, 0);
    summary();
  end
endmodule